// File: doc/BRIEF.md
# Tick-Synchronized Register Write Controller

This block stands between a fast host register bus and a timekeeping core that only updates on a slow tick. A host write to any synchronized register (time value, alarm value, prescaler enable, interrupt enable mask) is held in one shared staging register. It is committed to the core-facing output on the next selected tick. While that commit is outstanding, a pending flag is visible in the status word, and every further write to a synchronized register is thrown away. When the commit lands, a sticky completion flag is set.

The tick is chosen by the committed prescaler enable. When it is set, the slow tick input is used; when it is clear, the fast base-rate tick is used. The status word takes no part in the staging: writing ones to it clears the matching sticky bits on the next clock edge, even while a commit is outstanding. Event inputs from the core set the low status bits. The interrupt output combines the status bits with the committed enable mask.

Top module: `rwsync_ctrl`

## Requirements
- R1: After reset, no write is pending, the completion flag is 0, and all committed outputs (time, alarm, prescaler enable, enable mask, status) are 0. `irq_o` and `time_load_o` are 0.
- R2: A write to address 0 (time), 1 (alarm), 2 (prescaler enable, bit 0) or 3 (enable mask, bits 15:0) with no write pending sets status bit 14 at that clock edge. No committed output changes before a selected tick.
- R3: At the first clock edge where a write is pending and the selected tick is high, the staged value is copied to the addressed output. At that same edge, status bit 14 clears and status bit 15 sets.
- R4: A write to addresses 0 to 3 while status bit 14 is set is discarded. The staged value, the target address and the pending state are unchanged, and the earlier value is the one committed.
- R5: With the committed prescaler enable at 1, only `tick_slow_i` commits. With it at 0, only `tick_fast_i` commits. The other tick has no effect.
- R6: A write to address 4 clears at the next edge every status bit (except bit 14) whose `wr_data_i` bit is 1. It acts even while a commit is pending, and it leaves the pending state and the staged value untouched.
- R7: `evt_i[k]` high at an edge sets status bit k (k from 0 to 13), and the bit stays set until cleared. A set and a clear of the same bit at the same edge leave the bit set. The same rule applies to bit 15 against a commit.
- R8: `irq_o` is high exactly when some status bit other than bit 14 is set and the same bit of the committed enable mask is set.
- R9: `time_load_o` is high for exactly the one cycle after a commit to the time register, and it does not pulse for commits to other registers.
- R10: Writes to addresses 5 to 7 have no effect, and they do not set status bit 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_slow_i | input | 1 | Prescaled tick strobe, one cycle wide |
| tick_fast_i | input | 1 | Base-rate tick strobe, one cycle wide |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | DW | Write data |
| evt_i | input | 14 | Core event strobes for status bits 13:0 |
| time_o | output | DW | Committed time value |
| time_load_o | output | 1 | One-cycle pulse when time_o was just committed |
| alarm_o | output | DW | Committed alarm value |
| pren_o | output | 1 | Committed prescaler enable |
| ictl_o | output | 16 | Committed interrupt enable mask |
| istat_o | output | 16 | Status word: bit 15 complete, bit 14 pending, 13:0 events |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a pending commit that a tick must not release. This happens when the prescaler enable has just been committed to 1 and the fast tick, which released the previous commit, arrives again. The stimulus first commits the prescaler enable with a fast tick. It then stages a new mask, pulses the fast tick, and checks that the pending flag holds. Dropped writes and a status clear are also issued while the commit is outstanding. The test then confirms that the committed value is the first one written and that the pending flag survives the clear.

// File: rtl/rwsync_pkg.sv
package rwsync_pkg;
  localparam int SW       = 16;
  localparam int PEND_BIT = 14;
  localparam int DONE_BIT = 15;
  localparam int NEVT     = SW - 2;
  localparam int AW       = 3;

  typedef enum logic [AW-1:0] {
    ADR_TIME  = 3'd0,
    ADR_ALARM = 3'd1,
    ADR_PREN  = 3'd2,
    ADR_ICTL  = 3'd3,
    ADR_ISTAT = 3'd4
  } reg_adr_e;
endpackage

// File: rtl/rwsync_tick_sel.sv
module rwsync_tick_sel (
  input  logic pren_i,
  input  logic tick_slow_i,
  input  logic tick_fast_i,
  output logic tick_o
);
  assign tick_o = pren_i ? tick_slow_i : tick_fast_i;
endmodule

// File: rtl/rwsync_stager.sv
module rwsync_stager
  import rwsync_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          tick_i,
  output logic          pend_o,
  output logic          commit_o,
  output logic [AW-1:0] stg_addr_o,
  output logic [DW-1:0] stg_data_o
);
  logic is_sync, accept;

  assign is_sync  = (wr_addr_i == ADR_TIME) || (wr_addr_i == ADR_ALARM) ||
                    (wr_addr_i == ADR_PREN) || (wr_addr_i == ADR_ICTL);
  assign accept   = wr_en_i && is_sync && !pend_o;
  assign commit_o = pend_o && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o     <= 1'b0;
      stg_addr_o <= '0;
      stg_data_o <= '0;
    end else if (accept) begin
      pend_o     <= 1'b1;
      stg_addr_o <= wr_addr_i;
      stg_data_o <= wr_data_i;
    end else if (commit_o) begin
      pend_o     <= 1'b0;
    end
  end
endmodule

// File: rtl/rwsync_status.sv
module rwsync_status
  import rwsync_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEVT-1:0] evt_i,
  input  logic            clr_en_i,
  input  logic [SW-1:0]   clr_mask_i,
  input  logic            done_set_i,
  input  logic            pend_i,
  output logic [SW-1:0]   istat_o
);
  logic [SW-1:0] sticky_q, set_v, clr_v;

  assign set_v = {done_set_i, 1'b0, evt_i};
  assign clr_v = clr_en_i ? clr_mask_i : '0;

  // set wins over clear at the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= ((sticky_q & ~clr_v) | set_v) & ~(SW'(1) << PEND_BIT);
  end

  always_comb begin
    istat_o           = sticky_q;
    istat_o[PEND_BIT] = pend_i;
  end
endmodule

// File: rtl/rwsync_ctrl.sv
module rwsync_ctrl
  import rwsync_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_slow_i,
  input  logic            tick_fast_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [NEVT-1:0] evt_i,
  output logic [DW-1:0]   time_o,
  output logic            time_load_o,
  output logic [DW-1:0]   alarm_o,
  output logic            pren_o,
  output logic [SW-1:0]   ictl_o,
  output logic [SW-1:0]   istat_o,
  output logic            irq_o
);
  logic          tick, pend, commit;
  logic [AW-1:0] stg_addr;
  logic [DW-1:0] stg_data;
  logic          st_clr;

  rwsync_tick_sel u_tick (
    .pren_i      (pren_o),
    .tick_slow_i (tick_slow_i),
    .tick_fast_i (tick_fast_i),
    .tick_o      (tick)
  );

  rwsync_stager #(.DW(DW)) u_stg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .tick_i     (tick),
    .pend_o     (pend),
    .commit_o   (commit),
    .stg_addr_o (stg_addr),
    .stg_data_o (stg_data)
  );

  assign st_clr = wr_en_i && (wr_addr_i == ADR_ISTAT);

  rwsync_status u_st (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .clr_en_i   (st_clr),
    .clr_mask_i (wr_data_i[SW-1:0]),
    .done_set_i (commit),
    .pend_i     (pend),
    .istat_o    (istat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_o      <= '0;
      alarm_o     <= '0;
      pren_o      <= 1'b0;
      ictl_o      <= '0;
      time_load_o <= 1'b0;
    end else begin
      time_load_o <= commit && (stg_addr == ADR_TIME);
      if (commit) begin
        unique case (stg_addr)
          ADR_TIME:  time_o  <= stg_data;
          ADR_ALARM: alarm_o <= stg_data;
          ADR_PREN:  pren_o  <= stg_data[0];
          ADR_ICTL:  ictl_o  <= stg_data[SW-1:0];
          default:   ;
        endcase
      end
    end
  end

  assign irq_o = |(istat_o & ictl_o & ~(SW'(1) << PEND_BIT));
endmodule

// File: rtl/rwsync_chk.sv
module rwsync_chk
  import rwsync_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_slow_i,
  input logic          tick_fast_i,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] time_o,
  input logic          time_load_o,
  input logic [DW-1:0] alarm_o,
  input logic          pren_o,
  input logic [SW-1:0] ictl_o,
  input logic [SW-1:0] istat_o
);
  logic sel_tick;
  assign sel_tick = pren_o ? tick_slow_i : tick_fast_i;

  p_pend_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!istat_o[PEND_BIT] && wr_en_i && wr_addr_i <= 3'd3) |=> istat_o[PEND_BIT]);

  p_idle_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !istat_o[PEND_BIT] |=> ($stable(time_o) && $stable(alarm_o) && $stable(pren_o) && $stable(ictl_o)));

  p_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (istat_o[PEND_BIT] && sel_tick) |=> (!istat_o[PEND_BIT] && istat_o[DONE_BIT]));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (istat_o[PEND_BIT] && !sel_tick) |=> (istat_o[PEND_BIT] && $stable(time_o) && $stable(alarm_o)));

  p_load_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_load_o |=> !time_load_o);

  p_bad_addr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!istat_o[PEND_BIT] && wr_en_i && wr_addr_i >= 3'd5) |=> !istat_o[PEND_BIT]);
endmodule

bind rwsync_ctrl rwsync_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_slow_i (tick_slow_i),
  .tick_fast_i (tick_fast_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .time_o      (time_o),
  .time_load_o (time_load_o),
  .alarm_o     (alarm_o),
  .pren_o      (pren_o),
  .ictl_o      (ictl_o),
  .istat_o     (istat_o)
);

// File: tb/sim_rwsync_ctrl.sv
module sim_rwsync_ctrl;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick_slow_i = 1'b0;
  logic          tick_fast_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [2:0]    wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [13:0]   evt_i = '0;
  logic [DW-1:0] time_o, alarm_o;
  logic          time_load_o, pren_o, irq_o;
  logic [15:0]   ictl_o, istat_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  rwsync_ctrl #(.DW(DW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_slow_i(tick_slow_i), .tick_fast_i(tick_fast_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .evt_i(evt_i),
    .time_o(time_o), .time_load_o(time_load_o), .alarm_o(alarm_o), .pren_o(pren_o),
    .ictl_o(ictl_o), .istat_o(istat_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic pulse_slow();
    @(negedge clk_i); tick_slow_i = 1'b1;
    @(negedge clk_i); tick_slow_i = 1'b0;
  endtask

  task automatic pulse_fast();
    @(negedge clk_i); tick_fast_i = 1'b1;
    @(negedge clk_i); tick_fast_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pending", 32'(istat_o[14]), 0);
    chk("R1 istat", 32'(istat_o), 0);
    chk("R1 time", time_o, 0);
    chk("R1 alarm", alarm_o, 0);
    chk("R1 pren", 32'(pren_o), 0);
    chk("R1 ictl", 32'(ictl_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 load", 32'(time_load_o), 0);
  endtask

  task automatic t_basic();
    wr(3'd0, 32'h1234_5678);
    chk("R2 pending set", 32'(istat_o[14]), 1);
    chk("R2 time held", time_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R2 still pending", 32'(istat_o[14]), 1);
    pulse_slow();
    chk("R5 slow tick ignored pren0", 32'(istat_o[14]), 1);
    chk("R5 time held", time_o, 0);
    pulse_fast();
    chk("R3 time committed", time_o, 32'h1234_5678);
    chk("R3 pending cleared", 32'(istat_o[14]), 0);
    chk("R3 complete set", 32'(istat_o[15]), 1);
    chk("R9 load pulse", 32'(time_load_o), 1);
    @(negedge clk_i);
    chk("R9 load one cycle", 32'(time_load_o), 0);
  endtask

  task automatic t_drop();
    wr(3'd1, 32'h0000_000A);
    wr(3'd1, 32'h0000_000B);
    wr(3'd0, 32'h0000_0099);
    chk("R4 still pending", 32'(istat_o[14]), 1);
    pulse_fast();
    chk("R4 first alarm kept", alarm_o, 32'h0000_000A);
    chk("R4 time unchanged", time_o, 32'h1234_5678);
    chk("R9 no load on alarm", 32'(time_load_o), 0);
    chk("R4 pending clear after commit", 32'(istat_o[14]), 0);
  endtask

  task automatic t_clear();
    wr(3'd4, 32'h0000_8000);
    chk("R6 complete cleared", 32'(istat_o[15]), 0);
    wr(3'd1, 32'h0000_0055);
    wr(3'd4, 32'h0000_FFFF);
    chk("R6 pending survives clear", 32'(istat_o[14]), 1);
    pulse_fast();
    chk("R6 staged value intact", alarm_o, 32'h0000_0055);
    chk("R3 complete after commit", 32'(istat_o[15]), 1);
  endtask

  task automatic t_pren();
    wr(3'd2, 32'h1);
    pulse_fast();
    chk("R5 pren committed", 32'(pren_o), 1);
    wr(3'd3, 32'h0000_8004);
    pulse_fast();
    chk("R5 fast tick ignored pren1", 32'(istat_o[14]), 1);
    chk("R5 ictl held", 32'(ictl_o), 0);
    pulse_slow();
    chk("R5 slow tick commits", 32'(ictl_o), 32'h8004);
    chk("R5 pending cleared", 32'(istat_o[14]), 0);
  endtask

  task automatic t_irq();
    chk("R8 irq on complete", 32'(irq_o), 1);
    wr(3'd4, 32'h0000_8000);
    chk("R8 irq low after clear", 32'(irq_o), 0);
    @(negedge clk_i); evt_i = 14'h0004;
    @(negedge clk_i); evt_i = '0;
    chk("R7 event bit2 set", 32'(istat_o[2]), 1);
    chk("R8 irq on enabled event", 32'(irq_o), 1);
    @(negedge clk_i); evt_i = 14'h0008;
    @(negedge clk_i); evt_i = '0;
    repeat (2) @(negedge clk_i);
    chk("R7 event bit3 sticky", 32'(istat_o[3]), 1);
    @(negedge clk_i);
    evt_i = 14'h0004; wr_en_i = 1'b1; wr_addr_i = 3'd4; wr_data_i = 32'h0000_0004;
    @(negedge clk_i);
    evt_i = '0; wr_en_i = 1'b0; wr_data_i = '0;
    chk("R7 set wins over clear", 32'(istat_o[2]), 1);
    wr(3'd4, 32'h0000_000C);
    chk("R6 events cleared", 32'(istat_o[3:0]), 0);
    chk("R8 irq low masked bit3", 32'(irq_o), 0);
    wr(3'd3, 32'h0000_4000);
    pulse_slow();
    wr(3'd4, 32'h0000_8000);
    chk("R8 mask has bit14", 32'(ictl_o), 32'h4000);
    wr(3'd0, 32'h0000_0001);
    chk("R8 pending set", 32'(istat_o[14]), 1);
    chk("R8 pending excluded from irq", 32'(irq_o), 0);
    pulse_slow();
    chk("R9 load on time commit", 32'(time_load_o), 1);
  endtask

  task automatic t_badaddr();
    wr(3'd5, 32'hFFFF_FFFF);
    chk("R10 addr5 no pending", 32'(istat_o[14]), 0);
    wr(3'd7, 32'hFFFF_FFFF);
    chk("R10 addr7 no pending", 32'(istat_o[14]), 0);
    pulse_slow();
    chk("R10 time unchanged", time_o, 32'h1);
    chk("R10 alarm unchanged", alarm_o, 32'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_drop();
    t_clear();
    t_pren();
    t_irq();
    t_badaddr();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule